// File: doc/BRIEF.md
# Receive Sampling-Delay Tuner

This block is a hardware sequencer that picks the receive sampling delay for a high-speed eMMC link. After a start pulse it walks a tap index upward from zero through a fixed number of steps. Each tap is written into a control word that drives the delay line, together with an update-pending flag. The tuner waits until the delay line drops that flag, then asks a tuning-transfer agent to send one tuning block and reads back a pass/fail verdict.

While it sweeps, the tuner keeps two counts: the length of the current run of consecutive passing taps, and the longest run seen so far with the tap where that run ended. After the last tap it programs the tap in the middle of the longest run and pulses `done_o` once the delay line accepts it. If no tap passed, it pulses `done_o` and `err_o` together and programs nothing further. The transfer itself and the delay line sit outside the block.

Top module: `tap_window_tuner`

## Requirements
- R1: During and right after reset, `ctrl_o` is all zero and `xfer_req_o`, `done_o` and `err_o` are low.
- R2: A search visits taps 0, 1, ... NUM_TAPS-1 (default 40, taps 0 to 39) in ascending order. Each tap is placed in `ctrl_o[13:8]` with the update-pending flag `ctrl_o[15]` set. All other `ctrl_o` bits read zero. `xfer_req_o` is raised only after the flag has cleared, so each settled tap gets exactly one transfer request.
- R3: `xfer_req_o` stays high until the cycle in which `xfer_done_i` is sampled high. `xfer_pass_i` is taken as the verdict in that same cycle.
- R4: A passing tap adds one to the current run. When the run becomes strictly longer than the best run, the new length and the current tap are recorded.
- R5: A failing transfer, or a tap whose update timed out, sets the current run back to zero.
- R6: A later run of the same length as the recorded best does not replace it, so the earliest longest run wins.
- R7: The final tap is the best run's ending tap minus floor(best length / 2). It is applied with the update flag set. `done_o` is high for exactly one cycle, in the cycle after `upd_clr_i` is sampled high for that tap, and `err_o` stays low.
- R8: If no tap passes, `done_o` and `err_o` pulse together for one cycle after the last sweep step. No final tap is applied: `ctrl_o[13:8]` keeps the last swept tap and `ctrl_o[15]` stays clear.
- R9: If `upd_clr_i` does not arrive within UPD_LIMIT cycles (default 16) of a tap being applied, the flag is dropped, the tap counts as failed, and no transfer is requested for it.
- R10: If the final tap's update times out, `done_o` and `err_o` pulse together.
- R11: A start pulse that arrives while a search is running has no effect. The search completes with its normal result and no second sweep follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a search when the tuner is idle |
| xfer_req_o | output | 1 | Asks the transfer agent for one tuning block |
| xfer_done_i | input | 1 | Transfer agent has finished the requested block |
| xfer_pass_i | input | 1 | Verdict of that block, valid with `xfer_done_i` |
| upd_clr_i | input | 1 | Delay line has taken the tap; clears the update flag |
| ctrl_o | output | 16 | Control word: tap in bits 13:8, update flag in bit 15 |
| done_o | output | 1 | One-cycle end-of-search pulse |
| err_o | output | 1 | With `done_o`: no usable tap was found |

## Verification
The tap and the update flag appear on `ctrl_o` one cycle after the tuner enters its apply step. The request rises one cycle after `upd_clr_i` is sampled, and it falls one cycle after `xfer_done_i` is sampled. `done_o` follows the final `upd_clr_i` by one cycle. The bench models the transfer agent and the delay line, which respond on falling edges. It therefore reads `ctrl_o` and `xfer_req_o` half a cycle after the edge that changed them. For each search it waits for the falling edge where `done_o` is first seen and samples `err_o`, the tap field and the flag there. It then checks the very next falling edge to prove the pulse is one cycle long. Expected taps, error flags and request counts come from a vector table worked out from the requirements.

// File: rtl/tune_pkg.sv
package tune_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SET,
      ST_WAIT,
      ST_XFER,
      ST_STEP,
      ST_FSET,
      ST_FWAIT
   } tune_st_t;
endpackage

// File: rtl/upd_watch.sv
// Owns the update-pending flag and its optional settle timeout.
module upd_watch #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic clr_i,
   output logic pend_o,
   output logic ok_o,
   output logic expire_o
);
   logic pend_q;

   assign pend_o = pend_q;
   assign ok_o   = pend_q & clr_i;

   generate
      if (LIMIT == 0) begin : g_no_limit
         assign expire_o = 1'b0;
      end else begin : g_limit
         localparam int CNT_W = (LIMIT < 2) ? 1 : $clog2(LIMIT);
         logic [CNT_W-1:0] tmr_q;

         assign expire_o = pend_q & ~clr_i & (tmr_q == CNT_W'(LIMIT - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      tmr_q <= '0;
            else if (arm_i)  tmr_q <= '0;
            else if (pend_q) tmr_q <= tmr_q + CNT_W'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  pend_q <= 1'b0;
      else if (arm_i)              pend_q <= 1'b1;
      else if (ok_o || expire_o)   pend_q <= 1'b0;
   end
endmodule

// File: rtl/run_tracker.sv
// Tracks current and longest passing run and derives the centre tap.
module run_tracker #(
   parameter int TAP_W = 6,
   parameter int LEN_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             hit_i,
   input  logic             pass_i,
   input  logic [TAP_W-1:0] tap_i,
   output logic [LEN_W-1:0] best_len_o,
   output logic [TAP_W-1:0] centre_o
);
   logic [LEN_W-1:0] cur_q, best_q, cur_nx;
   logic [TAP_W-1:0] end_q;

   assign cur_nx     = cur_q + LEN_W'(1);
   assign best_len_o = best_q;
   assign centre_o   = end_q - TAP_W'(best_q >> 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q  <= '0;
         best_q <= '0;
         end_q  <= '0;
      end else if (clear_i) begin
         cur_q  <= '0;
         best_q <= '0;
         end_q  <= '0;
      end else if (hit_i) begin
         if (pass_i) begin
            cur_q <= cur_nx;
            if (cur_nx > best_q) begin   // strict: ties keep the earlier run
               best_q <= cur_nx;
               end_q  <= tap_i;
            end
         end else begin
            cur_q <= '0;
         end
      end
   end

   // R4: best length never shrinks within a search
   p_best_grows_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !clear_i |=> best_q >= $past(best_q));
endmodule

// File: rtl/tap_window_tuner.sv
module tap_window_tuner #(
   parameter int TAP_W     = 6,
   parameter int NUM_TAPS  = 40,
   parameter int UPD_LIMIT = 16,
   parameter int CTRL_W    = 16,
   parameter int TAP_LSB   = 8,
   parameter int UPD_BIT   = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic              xfer_req_o,
   input  logic              xfer_done_i,
   input  logic              xfer_pass_i,
   input  logic              upd_clr_i,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic              done_o,
   output logic              err_o
);
   import tune_pkg::*;

   localparam int LEN_W = $clog2(NUM_TAPS + 1);
   localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NUM_TAPS - 1);

   generate
      if (NUM_TAPS < 1 || NUM_TAPS > (1 << TAP_W)) begin : g_bad_taps
         $error("NUM_TAPS must lie in 1 .. 2**TAP_W");
      end
      if (TAP_LSB + TAP_W > UPD_BIT || UPD_BIT >= CTRL_W) begin : g_bad_layout
         $error("tap field must sit below the update bit inside CTRL_W");
      end
   endgenerate

   tune_st_t         st_q;
   logic [TAP_W-1:0] idx_q, tap_q;
   logic             done_q, err_q;
   logic             arm, pend, upd_ok, upd_exp, hit, pass, clear;
   logic [LEN_W-1:0] best_len;
   logic [TAP_W-1:0] centre;

   assign arm   = (st_q == ST_SET) || (st_q == ST_FSET);
   assign clear = (st_q == ST_IDLE) && start_i;
   assign hit   = ((st_q == ST_XFER) && xfer_done_i) || ((st_q == ST_WAIT) && upd_exp);
   assign pass  = (st_q == ST_XFER) && xfer_pass_i;

   upd_watch #(.LIMIT(UPD_LIMIT)) u_watch (
      .clk(clk), .rst_n(rst_n), .arm_i(arm), .clr_i(upd_clr_i),
      .pend_o(pend), .ok_o(upd_ok), .expire_o(upd_exp)
   );

   run_tracker #(.TAP_W(TAP_W), .LEN_W(LEN_W)) u_track (
      .clk(clk), .rst_n(rst_n), .clear_i(clear), .hit_i(hit), .pass_i(pass),
      .tap_i(idx_q), .best_len_o(best_len), .centre_o(centre)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         idx_q  <= '0;
         tap_q  <= '0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         unique case (st_q)
            ST_IDLE: if (start_i) begin
               idx_q <= '0;
               st_q  <= ST_SET;
            end
            ST_SET: begin
               tap_q <= idx_q;
               st_q  <= ST_WAIT;
            end
            ST_WAIT: begin
               if (upd_ok)       st_q <= ST_XFER;
               else if (upd_exp) st_q <= ST_STEP;
            end
            ST_XFER: if (xfer_done_i) st_q <= ST_STEP;
            ST_STEP: begin
               if (idx_q == LAST_TAP) begin
                  if (best_len == '0) begin
                     done_q <= 1'b1;
                     err_q  <= 1'b1;
                     st_q   <= ST_IDLE;
                  end else begin
                     st_q <= ST_FSET;
                  end
               end else begin
                  idx_q <= idx_q + TAP_W'(1);
                  st_q  <= ST_SET;
               end
            end
            ST_FSET: begin
               tap_q <= centre;
               st_q  <= ST_FWAIT;
            end
            ST_FWAIT: begin
               if (upd_ok) begin
                  done_q <= 1'b1;
                  st_q   <= ST_IDLE;
               end else if (upd_exp) begin
                  done_q <= 1'b1;
                  err_q  <= 1'b1;
                  st_q   <= ST_IDLE;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      ctrl_o = '0;
      ctrl_o[TAP_LSB +: TAP_W] = tap_q;
      ctrl_o[UPD_BIT]          = pend;
   end

   assign xfer_req_o = (st_q == ST_XFER);
   assign done_o     = done_q;
   assign err_o      = err_q;

   // R3: request held until the agent answers
   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req_o && !xfer_done_i) |=> xfer_req_o);
   // R2: no transfer while the delay line is still updating
   p_no_req_pending_r2: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_req_o |-> !ctrl_o[UPD_BIT]);
   // R2: tap field always inside the sweep range
   p_tap_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_o[TAP_LSB +: TAP_W] <= LAST_TAP);
   // R7: done is a single-cycle pulse
   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   // R8: error is only reported with done
   p_err_needs_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> done_o);
endmodule

// File: tb/tap_window_tuner_tb.sv
`timescale 1ns/1ps
module tap_window_tuner_tb;
   localparam int NUM = 40;

   typedef struct packed {
      logic [39:0] pat;
      logic [39:0] stuck;
      logic        err;
      logic [5:0]  tap;
      logic [6:0]  nreq;
   } vec_t;

   // pattern bit n = verdict at tap n; stuck bit n = delay line never settles tap n
   localparam vec_t VECS [8] = '{
      '{40'hFF_FFFF_FFFF, 40'h0,            1'b0, 6'd19, 7'd40}, // R4 full window
      '{40'h00_000F_FC00, 40'h0,            1'b0, 6'd14, 7'd40}, // R4 R5 taps 10..19
      '{40'h00_00F0_01E0, 40'h0,            1'b0, 6'd6,  7'd40}, // R6 equal runs
      '{40'h1F_C000_0007, 40'h0,            1'b0, 6'd33, 7'd40}, // R4 longer later
      '{40'h80_0000_0000, 40'h0,            1'b0, 6'd39, 7'd40}, // R7 single last tap
      '{40'h00_0000_0000, 40'h0,            1'b1, 6'd39, 7'd40}, // R8 nothing passes
      '{40'hFF_FFFF_FFFF, 40'h00_0000_8000, 1'b0, 6'd27, 7'd39}, // R9 timeout splits
      '{40'h00_0000_001F, 40'h0,            1'b0, 6'd2,  7'd40}  // R7 odd length at 0
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       xfer_done_i = 1'b0;
   logic       xfer_pass_i = 1'b0;
   logic       upd_clr_i = 1'b0;
   logic       xfer_req_o, done_o, err_o;
   logic [15:0] ctrl_o;

   logic [39:0] cur_pat = '0, cur_stuck = '0;
   logic        block_final = 1'b0;
   int          req_cnt = 0, apply_cnt = 0, ord_err = 0;
   int          n_run = 0, n_fail = 0;
   int          cyc = 0;

   always #2.5 clk = ~clk;

   tap_window_tuner u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .xfer_req_o(xfer_req_o), .xfer_done_i(xfer_done_i), .xfer_pass_i(xfer_pass_i),
      .upd_clr_i(upd_clr_i), .ctrl_o(ctrl_o), .done_o(done_o), .err_o(err_o)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // delay-line model
   initial begin
      forever begin
         @(negedge clk);
         if (ctrl_o[15]) begin
            if (apply_cnt < NUM && int'(ctrl_o[13:8]) != apply_cnt) ord_err++;
            if (cur_stuck[ctrl_o[13:8]] || (block_final && apply_cnt >= NUM)) begin
               apply_cnt++;
               while (ctrl_o[15]) @(negedge clk);
            end else begin
               apply_cnt++;
               repeat (2) @(negedge clk);
               upd_clr_i = 1'b1;
               @(negedge clk);
               upd_clr_i = 1'b0;
            end
         end
      end
   end

   // tuning-transfer agent model
   initial begin
      forever begin
         @(negedge clk);
         if (xfer_req_o) begin
            req_cnt++;
            xfer_pass_i = cur_pat[ctrl_o[13:8]];
            repeat (3) @(negedge clk);
            if (!xfer_req_o) ord_err++;   // R3 request must still be held
            xfer_done_i = 1'b1;
            @(negedge clk);
            xfer_done_i = 1'b0;
            xfer_pass_i = 1'b0;
         end
      end
   end

   // watchdog
   initial begin
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
         end
      end
   end

   task automatic run_case(input vec_t v, input bit mid_start, input bit blk,
                           input int exp_apply, input string tag);
      int w;
      cur_pat = v.pat;
      cur_stuck = v.stuck;
      block_final = blk;
      req_cnt = 0; apply_cnt = 0; ord_err = 0;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      w = 0;
      while (!done_o && w < 5000) begin
         @(negedge clk);
         w++;
         if (mid_start && w == 60) start_i = 1'b1;
         else start_i = 1'b0;
      end
      start_i = 1'b0;
      chk(done_o, {tag, " done seen"}, int'(done_o), 1);
      chk(err_o == v.err, {tag, " err flag"}, int'(err_o), int'(v.err));
      chk(ctrl_o[13:8] == v.tap, {tag, " final tap"}, int'(ctrl_o[13:8]), int'(v.tap));
      chk(ctrl_o[15] == 1'b0, {tag, " update flag clear"}, int'(ctrl_o[15]), 0);
      chk({ctrl_o[14], ctrl_o[7:0]} == '0, {tag, " R2 spare bits"}, int'(ctrl_o), 0);
      @(negedge clk);
      chk(!done_o, {tag, " R7 done width"}, int'(done_o), 0);
      repeat (30) @(negedge clk);
      chk(req_cnt == int'(v.nreq), {tag, " R2 R9 request count"}, req_cnt, int'(v.nreq));
      chk(ord_err == 0, {tag, " R2 R3 order"}, ord_err, 0);
      chk(apply_cnt == exp_apply, {tag, " applies"}, apply_cnt, exp_apply);
      chk(!xfer_req_o && !ctrl_o[15], {tag, " R11 idle after"}, int'(xfer_req_o), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(ctrl_o == '0, "R1 ctrl", int'(ctrl_o), 0);
      chk(!xfer_req_o && !done_o && !err_o, "R1 outputs", int'({xfer_req_o, done_o, err_o}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ctrl_o == '0 && !xfer_req_o, "R1 after release", int'(ctrl_o), 0);

      // vector table
      for (int i = 0; i < 8; i++) begin
         run_case(VECS[i], 1'b0, 1'b0, VECS[i].err ? NUM : NUM + 1,
                  $sformatf("vec%0d", i));
      end

      // R11 start while busy is ignored
      run_case(VECS[1], 1'b1, 1'b0, NUM + 1, "R11 busy start");

      // R10 final tap update times out
      run_case('{40'hFF_FFFF_FFFF, 40'h0, 1'b1, 6'd19, 7'd40}, 1'b0, 1'b1, NUM + 1,
               "R10 final timeout");

      // R1 reset in mid-search returns to idle
      cur_pat = '1; cur_stuck = '0; block_final = 1'b0;
      @(negedge clk); start_i = 1'b1;
      @(negedge clk); start_i = 1'b0;
      repeat (40) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(ctrl_o == '0 && !xfer_req_o && !done_o, "R1 mid reset", int'(ctrl_o), 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule